// File: doc/BRIEF.md
# Timed configuration readback controller

This block holds the two arming bits of a self-programming control register. It opens a short, cycle-counted window in which a program-memory load returns a configuration byte instead of flash data. Software writes the control bits through a simple write port and then issues load or store strobes with a 16-bit pointer. While the window is open, a load picks one of three configuration bytes by pointer address: the lock byte, the fuse low byte or the fuse high byte. At any other time, a load returns the flash read data that is supplied alongside it.

The window closes by itself in two ways. It closes when a configuration read consumes it. It also closes when it expires: a load counts only in the first three cycles after arming, and a store counts only in the first four. An EEPROM write in progress blocks writes to the control register and suppresses configuration reads. Fuse and lock values arrive on static inputs and pass through bit for bit, so a programmed bit reads 0 and an unprogrammed bit reads 1.

Top module: `cfg_readback_ctrl`

## Requirements
- R1: After reset, `ctrl_o` is 2'b00 and `rdata_o` is 8'h00.
- R2: A write with `ee_busy_i` low loads `ctrl_wdata_i` into the control bits, visible on `ctrl_o` after the edge. Bit 0 is the program-enable bit and bit 1 is the configuration-select bit. The window is armed when both bits are 1.
- R3: Define the arming edge as the edge that registers the write. A load presented in the first, second or third cycle after the arming edge, with pointer 0x0001, returns {2'b11, lock_bits_i} on `rdata_o` after the edge that samples it.
- R4: In the same window, pointer 0x0000 returns `fuse_lo_i` and pointer 0x0003 returns `fuse_hi_i`.
- R5: In the window, any other pointer value returns 8'hFF.
- R6: A redirected load clears both control bits on the same edge.
- R7: If the window is not used, both bits clear on the fourth edge after the arming edge. A load sampled on that edge returns flash data.
- R8: A store strobe sampled while the program-enable bit is set clears both control bits.
- R9: While `ee_busy_i` is high, control writes are ignored. Loads in that state return flash data and do not consume the window.
- R10: With the window not armed, including with only the program-enable bit set, a load returns `flash_rdata_i`. `rdata_o` holds its value in cycles without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 2 | Control write data: bit 1 config select, bit 0 program enable |
| lpm_i | input | 1 | Program-memory load strobe |
| spm_i | input | 1 | Program-memory store strobe |
| zptr_i | input | 16 | Pointer address |
| flash_rdata_i | input | 8 | Flash read data for the current pointer |
| ee_busy_i | input | 1 | EEPROM write in progress |
| lock_bits_i | input | 6 | Lock bits (0 = programmed) |
| fuse_lo_i | input | 8 | Fuse low byte |
| fuse_hi_i | input | 8 | Fuse high byte |
| ctrl_o | output | 2 | Current control bits {config select, program enable} |
| rdata_o | output | 8 | Registered load result |

## Verification
The bench probes the window at both of its edges. A load in the third cycle after arming must still be redirected. A load in the fourth cycle must return flash data. A counter that is off by one would either leak a configuration byte after expiry or refuse a legal read. Consumption is checked by reading twice in a row: a design that did not clear the bits would return the configuration byte a second time. Busy periods are exercised in two ways, with a control write during busy and with a load inside an open window during busy. A design that let either through would change `ctrl_o` or return a configuration byte. Unmapped pointers and the case where only the enable bit is set would expose a decoder that defaults to flash data or to the lock byte.

// File: rtl/cfg_readback_pkg.sv
package cfg_readback_pkg;
  typedef struct packed {
    logic cfg;  // configuration-select bit
    logic en;   // program-enable bit
  } ctrl_t;
endpackage

// File: rtl/cfg_readback_arm.sv
module cfg_readback_arm
  import cfg_readback_pkg::*;
#(
  parameter int LPM_WIN = 3,
  parameter int SPM_WIN = 4,
  parameter int CNT_W   = $clog2(SPM_WIN + 1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_ok_i,
  input  ctrl_t wdata_i,
  input  logic  lpm_i,
  input  logic  spm_i,
  input  logic  busy_i,
  output ctrl_t ctrl_o,
  output logic  redir_o
);
  localparam logic [CNT_W-1:0] LpmLim  = CNT_W'(LPM_WIN);
  localparam logic [CNT_W-1:0] SpmLast = CNT_W'(SPM_WIN - 1);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] age_q;
  logic             in_lpm_win, consume, expire;

  assign in_lpm_win = ctrl_q.en && (age_q < LpmLim);
  assign redir_o    = lpm_i && ctrl_q.en && ctrl_q.cfg && in_lpm_win && !busy_i;
  assign consume    = redir_o || (spm_i && ctrl_q.en);
  assign expire     = ctrl_q.en && (age_q == SpmLast);
  assign ctrl_o     = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      age_q  <= '0;
    end else if (wr_ok_i) begin
      ctrl_q <= wdata_i;
      age_q  <= '0;
    end else if (consume || expire) begin
      ctrl_q <= '0;
      age_q  <= '0;
    end else if (ctrl_q.en) begin
      age_q  <= age_q + 1'b1;
    end
  end

  p_use_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_o && !wr_ok_i) |=> (ctrl_q == '0));

  p_store_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spm_i && ctrl_q.en && !wr_ok_i) |=> (ctrl_q == '0));

  p_expiry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && age_q == SpmLast && !wr_ok_i) |=> !ctrl_q.en);

  p_age_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q <= SpmLast);

  p_busy_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !ctrl_q.en) |=> $stable(ctrl_q));

  p_no_redir_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !redir_o);
endmodule

// File: rtl/cfg_readback_sel.sv
module cfg_readback_sel #(
  parameter int                 ADDR_W = 16,
  parameter int                 DATA_W = 8,
  parameter int                 LOCK_W = 6,
  parameter logic [ADDR_W-1:0]  Z_FLO  = 'h0,
  parameter logic [ADDR_W-1:0]  Z_LOCK = 'h1,
  parameter logic [ADDR_W-1:0]  Z_FHI  = 'h3
) (
  input  logic [ADDR_W-1:0] zptr_i,
  input  logic [LOCK_W-1:0] lock_i,
  input  logic [DATA_W-1:0] fuse_lo_i,
  input  logic [DATA_W-1:0] fuse_hi_i,
  output logic [DATA_W-1:0] cfg_byte_o
);
  localparam int PAD_W = DATA_W - LOCK_W;

  logic [DATA_W-1:0] lock_byte;

  // unused lock-byte positions read as unprogrammed
  generate
    if (PAD_W > 0) begin : g_pad
      assign lock_byte = {{PAD_W{1'b1}}, lock_i};
    end else begin : g_nopad
      assign lock_byte = lock_i[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (zptr_i)
      Z_LOCK:  cfg_byte_o = lock_byte;
      Z_FLO:   cfg_byte_o = fuse_lo_i;
      Z_FHI:   cfg_byte_o = fuse_hi_i;
      default: cfg_byte_o = '1;
    endcase
  end
endmodule

// File: rtl/cfg_readback_rdpath.sv
module cfg_readback_rdpath #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lpm_i,
  input  logic              redir_i,
  input  logic [DATA_W-1:0] cfg_byte_i,
  input  logic [DATA_W-1:0] flash_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (lpm_i)   rdata_o <= redir_i ? cfg_byte_i : flash_i;
  end

  p_flash_when_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpm_i && !redir_i) |=> (rdata_o == $past(flash_i)));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lpm_i |=> $stable(rdata_o));

  p_cfg_when_armed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpm_i && redir_i) |=> (rdata_o == $past(cfg_byte_i)));
endmodule

// File: rtl/cfg_readback_ctrl.sv
module cfg_readback_ctrl
  import cfg_readback_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int LOCK_W  = 6,
  parameter int LPM_WIN = 3,
  parameter int SPM_WIN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [1:0]        ctrl_wdata_i,
  input  logic              lpm_i,
  input  logic              spm_i,
  input  logic [ADDR_W-1:0] zptr_i,
  input  logic [DATA_W-1:0] flash_rdata_i,
  input  logic              ee_busy_i,
  input  logic [LOCK_W-1:0] lock_bits_i,
  input  logic [DATA_W-1:0] fuse_lo_i,
  input  logic [DATA_W-1:0] fuse_hi_i,
  output logic [1:0]        ctrl_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctrl_t             ctrl_s;
  logic              wr_ok, redir;
  logic [DATA_W-1:0] cfg_byte;

  assign wr_ok  = ctrl_we_i && !ee_busy_i;
  assign ctrl_o = ctrl_s;

  cfg_readback_arm #(
    .LPM_WIN(LPM_WIN), .SPM_WIN(SPM_WIN)
  ) u_arm (
    .clk_i, .rst_ni,
    .wr_ok_i (wr_ok),
    .wdata_i (ctrl_t'(ctrl_wdata_i)),
    .lpm_i, .spm_i,
    .busy_i  (ee_busy_i),
    .ctrl_o  (ctrl_s),
    .redir_o (redir)
  );

  cfg_readback_sel #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_W(LOCK_W)
  ) u_sel (
    .zptr_i, .lock_i(lock_bits_i), .fuse_lo_i, .fuse_hi_i,
    .cfg_byte_o(cfg_byte)
  );

  cfg_readback_rdpath #(.DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni, .lpm_i,
    .redir_i(redir), .cfg_byte_i(cfg_byte),
    .flash_i(flash_rdata_i), .rdata_o
  );

  p_busy_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ee_busy_i && ctrl_o[0] == 1'b0) |=> $stable(ctrl_o));

  p_write_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ee_busy_i) |=> (ctrl_o == $past(ctrl_wdata_i)));
endmodule

// File: tb/cfg_readback_ctrl_tb_top.sv
module cfg_readback_ctrl_tb_top;
  logic clk = 0, rst_ni = 0;
  logic we = 0, lpm = 0, spm = 0, busy = 0;
  logic [1:0]  wd = 0;
  logic [15:0] z = 0;
  logic [7:0]  flash;
  logic [5:0]  lock = 6'b101001;
  logic [7:0]  flo = 8'hE1, fhi = 8'h99;
  logic [1:0]  ctrl;
  logic [7:0]  rdata;
  int checks = 0, errors = 0;
  bit live = 0;

  // reference model state
  bit m_en = 0, m_cfg = 0;
  int m_age = 0;
  logic [7:0] m_rd = 0;

  always #5 clk = ~clk;
  assign flash = z[7:0] ^ 8'h5A;

  cfg_readback_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(we), .ctrl_wdata_i(wd),
    .lpm_i(lpm), .spm_i(spm), .zptr_i(z), .flash_rdata_i(flash),
    .ee_busy_i(busy), .lock_bits_i(lock), .fuse_lo_i(flo), .fuse_hi_i(fhi),
    .ctrl_o(ctrl), .rdata_o(rdata)
  );

  function automatic logic [7:0] cfg_of(input logic [15:0] a);
    if (a == 16'h0001) return {2'b11, lock};
    if (a == 16'h0000) return flo;
    if (a == 16'h0003) return fhi;
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_en = 0; m_cfg = 0; m_age = 0; m_rd = 0;
    end else begin
      bit use_it;
      use_it = lpm && m_en && m_cfg && m_age < 3 && !busy;
      if (lpm) m_rd = use_it ? cfg_of(z) : flash;
      if (we && !busy) begin
        m_en = wd[0]; m_cfg = wd[1]; m_age = 0;
      end else if (m_en && (use_it || spm || m_age == 3)) begin
        m_en = 0; m_cfg = 0; m_age = 0;
      end else if (m_en) m_age++;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk("R2 R3 model ctrl", {6'd0, ctrl}, {6'd0, m_cfg, m_en});
    chk("R10 model rdata", rdata, m_rd);
  end

  task automatic step(input bit w, input logic [1:0] d, input bit l, input bit s,
                      input logic [15:0] a, input bit b);
    we = w; wd = d; lpm = l; spm = s; z = a; busy = b;
    @(negedge clk);
    we = 0; lpm = 0; spm = 0; busy = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 16'h0040, 0);
  endtask

  task automatic arm();
    step(1, 2'b11, 0, 0, 16'h0040, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctrl", {6'd0, ctrl}, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    rst_ni = 1; live = 1;
    @(negedge clk);
    // R2 + R3 + R6
    arm();
    chk("R2 armed", {6'd0, ctrl}, 8'h03);
    step(0, 0, 1, 0, 16'h0001, 0);
    chk("R3 lock", rdata, {2'b11, lock});
    chk("R6 cleared", {6'd0, ctrl}, 8'h00);
    step(0, 0, 1, 0, 16'h0001, 0);
    chk("R6 second read flash", rdata, 8'h01 ^ 8'h5A);
    // R4 at last legal cycle
    arm(); idle(2);
    step(0, 0, 1, 0, 16'h0000, 0);
    chk("R4 fuse low", rdata, flo);
    arm(); idle(1);
    step(0, 0, 1, 0, 16'h0003, 0);
    chk("R4 fuse high", rdata, fhi);
    // R5
    arm();
    step(0, 0, 1, 0, 16'h0005, 0);
    chk("R5 unmapped", rdata, 8'hFF);
    arm();
    step(0, 0, 1, 0, 16'h0100, 0);
    chk("R5 high addr", rdata, 8'hFF);
    // R7 expiry
    arm(); idle(3);
    chk("R7 still armed", {6'd0, ctrl}, 8'h03);
    step(0, 0, 1, 0, 16'h0001, 0);
    chk("R7 late load flash", rdata, 8'h01 ^ 8'h5A);
    chk("R7 expired", {6'd0, ctrl}, 8'h00);
    // R8
    arm();
    step(0, 0, 0, 1, 16'h0040, 0);
    chk("R8 store clears", {6'd0, ctrl}, 8'h00);
    step(1, 2'b01, 0, 0, 16'h0040, 0); idle(2);
    step(0, 0, 0, 1, 16'h0040, 0);
    chk("R8 store clears enable", {6'd0, ctrl}, 8'h00);
    // R9
    step(1, 2'b11, 0, 0, 16'h0040, 1);
    chk("R9 write blocked", {6'd0, ctrl}, 8'h00);
    arm();
    step(0, 0, 1, 0, 16'h0003, 1);
    chk("R9 busy load flash", rdata, 8'h03 ^ 8'h5A);
    chk("R9 not consumed", {6'd0, ctrl}, 8'h03);
    step(0, 0, 1, 0, 16'h0003, 0);
    chk("R9 read after busy", rdata, fhi);
    // R10
    idle(1);
    step(0, 0, 1, 0, 16'h0022, 0);
    chk("R10 disarmed", rdata, 8'h22 ^ 8'h5A);
    idle(2);
    chk("R10 hold", rdata, 8'h22 ^ 8'h5A);
    step(1, 2'b01, 0, 0, 16'h0040, 0);
    step(0, 0, 1, 0, 16'h0001, 0);
    chk("R10 enable only", rdata, 8'h01 ^ 8'h5A);
    idle(6);
    live = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule